// File: doc/BRIEF.md
# Dual-Mode Serial LED Shifter

The block drives a bank of status LEDs through three pins: a slow serial clock, a serial data line and a latch strobe. It divides the system clock down to an LED clock of at most 720 Hz. Each LED clock period it presents one bit of a frame on the data line. It takes a parallel LED status word and a one-bit format select. It can feed either a 36-step serial display-driver chip that needs no latch, or a cascade of 8-bit shift-and-latch registers that needs a latch strobe and inverted data.

A sequencer state machine walks each frame. It has five states: `ST_WAIT` is the single idle period after reset. `ST_START` sends the leading start bit, which exists only in the display-driver format. `ST_SHIFT` sends the LED bits in index order. `ST_PAD` sends the filler bits. `ST_LATCH` sends the strobe period, which exists only in the shift-register format.

The transitions all happen on an LED clock falling edge:
- WAIT goes to START or SHIFT, with a frame load.
- START goes to SHIFT.
- SHIFT goes to PAD after the last LED bit.
- PAD goes to LATCH in the shift-register format, or to a new frame in the display-driver format.
- LATCH goes to a new frame.

On every frame load the status word and the format select are copied into shadow state. This keeps a frame intact when the inputs change while it is being shifted out.

Top module: `led_serial_shifter`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), `led_clk`, `led_data` and `led_latch` are all low and the selected format reverts to display-driver (mode 0).
- R2: `led_clk` runs without pause in both formats, with a period of exactly 2*HALF_DIV system clocks and equal high and low halves.
- R3: `led_data` changes only in the system cycle in which `led_clk` falls, so it is stable at every `led_clk` rising edge.
- R4: `ctrl_mode` (0 = display-driver, 1 = shift-register) is sampled only at a frame boundary; a switch takes effect from the next frame on.
- R5: A display-driver frame lasts 36 LED clock periods: a start bit of 1, then the 30 LED bits with bit 0 first, then 5 zero bits.
- R6: In display-driver format `led_data` is true (a 1 bit drives the pin high) and `led_latch` stays low.
- R7: A shift-register frame lasts 33 periods: the 30 LED bits with bit 0 first, 2 zero fill bits completing four 8-bit registers, then one strobe period.
- R8: In shift-register format `led_data` is inverted (a 1 bit drives the pin low); during the strobe period the pin carries an inverted zero, i.e. high.
- R9: `led_latch` is high for exactly one whole LED clock period, at the end of each shift-register frame, and never in display-driver format.
- R10: The status word and `ctrl_mode` are captured at frame start; changing them during a frame has no effect on that frame's bits.
- R11: After reset one idle period (data and latch low) precedes the first frame, which begins at the first `led_clk` falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_mode | input | 1 | Format select from the control register bit 0 |
| led_status | input | NUM_LEDS | Parallel LED status word, bit 0 sent first |
| led_clk | output | 1 | Divided serial LED clock |
| led_data | output | 1 | Serial LED data, polarity set by the format |
| led_latch | output | 1 | Latch strobe for the shift-register chain |

## Verification
The assertions check these properties on every cycle:
- The prescaler toggles only at its terminal count.
- The data pin moves only at an LED clock falling edge.
- The captured format and status word hold between frame loads.
- The strobe appears only in the shift-register format.
- The bit index stays in range.

Only the bench's scenarios can show the bit-exact content and length of each frame, the polarity in each format, and the exact frame where a format switch takes effect. The bench also shows that status and mode changes made in mid-frame do not reach the pins until the next frame.

// File: rtl/led_shift_pkg.sv
package led_shift_pkg;

    typedef enum logic [2:0] {
        ST_WAIT  = 3'd0,
        ST_START = 3'd1,
        ST_SHIFT = 3'd2,
        ST_PAD   = 3'd3,
        ST_LATCH = 3'd4
    } seq_state_t;

    typedef enum logic {
        MODE_DRV = 1'b0,
        MODE_SR  = 1'b1
    } frame_mode_t;

endpackage

// File: rtl/led_clk_prescaler.sv
module led_clk_prescaler #(
    parameter int HALF_DIV = 34723
) (
    input  logic clk,
    input  logic rst_n,
    output logic led_clk,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          clk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            clk_q <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            clk_q <= ~clk_q;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign led_clk   = clk_q;
    // high half ends now: the sequencer advances on this cycle
    assign fall_tick = (cnt == LAST) && clk_q;

    assert_toggle_terminal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_q != $past(clk_q)) |-> ($past(cnt) == LAST));

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/led_frame_seq.sv
module led_frame_seq
    import led_shift_pkg::*;
#(
    parameter int NUM_LEDS  = 30,
    parameter int DRV_FRAME = 36,
    parameter int REG_BITS  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                ctrl_mode,
    input  logic [NUM_LEDS-1:0] led_status,
    output seq_state_t          state,
    output frame_mode_t         mode_q,
    output logic                bit_val
);
    localparam int DRV_PAD = DRV_FRAME - 1 - NUM_LEDS;
    localparam int SR_LEN  = ((NUM_LEDS + REG_BITS - 1) / REG_BITS) * REG_BITS;
    localparam int SR_PAD  = SR_LEN - NUM_LEDS;
    localparam int MAX_PAD = (DRV_PAD > SR_PAD) ? DRV_PAD : SR_PAD;
    localparam int PW      = $clog2(MAX_PAD + 2);
    localparam int IW      = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(NUM_LEDS - 1);

    seq_state_t          nxt_state;
    logic [IW-1:0]       idx;
    logic [PW-1:0]       pad_cnt;
    logic [PW-1:0]       pad_len;
    logic [NUM_LEDS-1:0] shadow;
    logic                load;
    logic                idx_last;

    assign pad_len  = (mode_q == MODE_SR) ? PW'(SR_PAD) : PW'(DRV_PAD);
    assign idx_last = (idx == IDX_LAST);

    // next-state decision, applied only on a step
    always_comb begin
        nxt_state = state;
        load      = 1'b0;
        unique case (state)
            ST_WAIT:  load = 1'b1;
            ST_START: nxt_state = ST_SHIFT;
            ST_SHIFT: begin
                if (idx_last) begin
                    if (pad_len != '0)          nxt_state = ST_PAD;
                    else if (mode_q == MODE_SR) nxt_state = ST_LATCH;
                    else                        load = 1'b1;
                end
            end
            ST_PAD: begin
                if (pad_cnt == pad_len - PW'(1)) begin
                    if (mode_q == MODE_SR) nxt_state = ST_LATCH;
                    else                   load = 1'b1;
                end
            end
            ST_LATCH: load = 1'b1;
            default:  load = 1'b1;
        endcase
        if (load) nxt_state = ctrl_mode ? ST_SHIFT : ST_START;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= ST_WAIT;
        else if (step) state <= nxt_state;
    end

    // frame datapath: shadow capture, bit index, fill counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            pad_cnt <= '0;
            shadow  <= '0;
            mode_q  <= MODE_DRV;
        end else if (step) begin
            if (load) begin
                shadow  <= led_status;
                mode_q  <= frame_mode_t'(ctrl_mode);
                idx     <= '0;
                pad_cnt <= '0;
            end else begin
                if (state == ST_SHIFT && !idx_last) idx <= idx + IW'(1);
                if (state == ST_PAD) pad_cnt <= pad_cnt + PW'(1);
            end
        end
    end

    // logical bit of the current period, before polarity
    always_comb begin
        unique case (state)
            ST_START: bit_val = 1'b1;
            ST_SHIFT: bit_val = shadow[idx];
            default:  bit_val = 1'b0;
        endcase
    end

    assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_LAST);

    assert_mode_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && load) |=> $stable(mode_q));

    assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && load) |=> $stable(shadow));

    assert_latch_sr_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH) |-> (mode_q == MODE_SR));

endmodule

// File: rtl/led_pin_driver.sv
module led_pin_driver
    import led_shift_pkg::*;
(
    input  seq_state_t  state,
    input  frame_mode_t mode_q,
    input  logic        bit_val,
    output logic        pin_data,
    output logic        pin_latch
);
    always_comb begin
        unique case (mode_q)
            MODE_SR:  pin_data = ~bit_val;
            default:  pin_data = bit_val;
        endcase
        pin_latch = (state == ST_LATCH);
    end
endmodule

// File: rtl/led_serial_shifter.sv
module led_serial_shifter
    import led_shift_pkg::*;
#(
    parameter int HALF_DIV  = 34723,
    parameter int NUM_LEDS  = 30,
    parameter int DRV_FRAME = 36,
    parameter int REG_BITS  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_mode,
    input  logic [NUM_LEDS-1:0] led_status,
    output logic                led_clk,
    output logic                led_data,
    output logic                led_latch
);
    logic        fall_tick;
    logic        bit_val;
    seq_state_t  state;
    frame_mode_t mode_q;

    led_clk_prescaler #(.HALF_DIV(HALF_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .led_clk   (led_clk),
        .fall_tick (fall_tick)
    );

    led_frame_seq #(
        .NUM_LEDS  (NUM_LEDS),
        .DRV_FRAME (DRV_FRAME),
        .REG_BITS  (REG_BITS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (fall_tick),
        .ctrl_mode  (ctrl_mode),
        .led_status (led_status),
        .state      (state),
        .mode_q     (mode_q),
        .bit_val    (bit_val)
    );

    led_pin_driver u_pins (
        .state     (state),
        .mode_q    (mode_q),
        .bit_val   (bit_val),
        .pin_data  (led_data),
        .pin_latch (led_latch)
    );

    assert_data_at_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(led_clk) |-> $stable(led_data));

    assert_latch_low_drv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DRV) |-> !led_latch);

    assert_latch_at_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(led_clk) |-> $stable(led_latch));

endmodule

// File: tb/sim_led_serial_shifter.sv
module sim_led_serial_shifter;
    localparam int HALF = 3;
    localparam int NL   = 30;
    localparam int NFR  = 6;

    typedef struct {
        logic  d;
        logic  l;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_mode = 1'b0;
    logic [NL-1:0] led_status = '0;
    logic          led_clk, led_data, led_latch;

    int   total = 0;
    int   bad = 0;
    int   rise_cnt = 0;
    int   cyc = 0;
    int   last_rise_cyc = -1;
    bit   done = 1'b0;
    logic prev_lc = 1'b0;
    logic prev_d  = 1'b0;
    exp_t exp_q[$];

    always #10 clk = ~clk;  // 50 MHz

    led_serial_shifter #(.HALF_DIV(HALF), .NUM_LEDS(NL)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_mode  (ctrl_mode),
        .led_status (led_status),
        .led_clk    (led_clk),
        .led_data   (led_data),
        .led_latch  (led_latch)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic d, input logic l, input string tag);
        exp_t e;
        e.d = d; e.l = l; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // expected pin values per LED clock period, built from R5..R9
    task automatic push_frame(input logic m, input logic [NL-1:0] s, input string tag);
        if (!m) begin
            push(1'b1, 1'b0, {tag, " R5 start"});
            for (int i = 0; i < NL; i++) push(s[i], 1'b0, {tag, " R6 bit"});
            for (int i = 0; i < 5; i++)  push(1'b0, 1'b0, {tag, " R5 fill"});
        end else begin
            for (int i = 0; i < NL; i++) push(~s[i], 1'b0, {tag, " R8 bit"});
            for (int i = 0; i < 2; i++)  push(1'b1, 1'b0, {tag, " R7 fill"});
            push(1'b1, 1'b1, {tag, " R9 strobe"});
        end
    endtask

    // monitor: compares on every LED clock rising edge, away from clk edges
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            if (led_clk && !prev_lc) begin
                rise_cnt++;
                if (last_rise_cyc >= 0)
                    check((cyc - last_rise_cyc) == 2*HALF, "R2", "led_clk period",
                          cyc - last_rise_cyc, 2*HALF);
                last_rise_cyc = cyc;
                check(led_data == prev_d, "R3", "data moved at rise", led_data, prev_d);
                if (exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(led_data == e.d, e.tag, "led_data", led_data, e.d);
                    check(led_latch == e.l, e.tag, "led_latch", led_latch, e.l);
                end else begin
                    check(1'b0, "R7", "unexpected period", 0, 1);
                end
            end
        end
        prev_lc = led_clk;
        prev_d  = led_data;
    end

    initial begin
        logic          fm [NFR];
        logic [NL-1:0] fs [NFR];
        string         ft [NFR];
        int            flen;
        int            target;
        fm[0] = 1'b0; fs[0] = 30'h2AAA_AAAA; ft[0] = "R5";
        fm[1] = 1'b0; fs[1] = 30'h0123_4567; ft[1] = "R6 R10";
        fm[2] = 1'b1; fs[2] = 30'h3FFF_0001; ft[2] = "R4 to-shift";
        fm[3] = 1'b1; fs[3] = 30'h1555_5555; ft[3] = "R7 R10";
        fm[4] = 1'b0; fs[4] = 30'h3000_00FF; ft[4] = "R4 to-driver";
        fm[5] = 1'b1; fs[5] = 30'h0000_0000; ft[5] = "R8";

        ctrl_mode  = fm[0];
        led_status = fs[0];
        repeat (4) @(negedge clk);
        // R1: reset levels
        check(led_clk == 1'b0, "R1", "led_clk in reset", led_clk, 0);
        check(led_data == 1'b0, "R1", "led_data in reset", led_data, 0);
        check(led_latch == 1'b0, "R1", "led_latch in reset", led_latch, 0);
        push(1'b0, 1'b0, "R11 idle");
        push_frame(fm[0], fs[0], ft[0]);
        rst_n = 1'b1;

        target = 1;  // the idle period's rise
        for (int k = 0; k < NFR; k++) begin
            flen = fm[k] ? 33 : 36;
            wait (rise_cnt >= target + 1);
            if (k < NFR - 1) begin
                // R10: garbage mid-frame first, then the next frame's values
                ctrl_mode  = ~fm[k+1];
                led_status = ~fs[k+1];
                wait (rise_cnt >= target + 5);
                ctrl_mode  = fm[k+1];
                led_status = fs[k+1];
                push_frame(fm[k+1], fs[k+1], ft[k+1]);
            end
            target += flen;
        end
        wait (rise_cnt >= target);
        done = 1'b1;
        check(exp_q.size() == 0, "R7", "items left", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R2: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule